// File: doc/BRIEF.md
# Pixel-Doubled Packed Framebuffer Scanout

This block drives a 640x480 raster from a 320x240 image stored at two bits per pixel in on-chip synchronous RAM. It holds the horizontal and vertical position counters and makes the active-low sync pulses and the display-enable signal from them. Every displayed pixel and every displayed line is shown twice, so each stored pixel fills a 2x2 screen block. A four-entry colour table, which can be reloaded, turns each 2-bit code into a 12-bit RGB value.

The image sits in sixteen 8-bit-wide banks. A byte holds four pixels, so one stored line takes 80 bytes, and one bank holds sixteen stored lines of 128 byte slots. The counter bits give the word address, the bank and the pixel slot directly, with no arithmetic. The read is issued from the live counters. The syncs, the enable and the slot select are delayed through the same two register stages as the pixel data, so all outputs stay aligned. A host updates the image through its own write port, which shares no cycles with scanout.

Top module: `vga_fb_reader`

## Requirements
- R1: While rst_ni is low, hsync_o=1, vsync_o=1, de_o=0 and rgb_o=0.
- R2: A line lasts H_VIS+H_FP+H_SYNC+H_BP clocks. hsync_o is low for exactly H_SYNC clocks, starting H_VIS+H_FP clocks after the first visible pixel of the line.
- R3: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines. vsync_o is low for exactly V_SYNC whole lines, starting at line V_VIS+V_FP.
- R4: de_o is high exactly for columns below H_VIS on lines below V_VIS, and it is high for H_VIS consecutive clocks per line. Whenever de_o is low, rgb_o is 0, whatever the memory holds.
- R5: Screen pixel (x,y) reads bank y[8:5], word address {y[4:1], x[9:3]} (11 bits) and pixel slot x[2:1].
- R6: Slot 0 of a byte is bits [7:6], slot 1 is bits [5:4], slot 2 is bits [3:2] and slot 3 is bits [1:0].
- R7: Each stored pixel appears on two adjacent columns and on two adjacent lines.
- R8: After reset the colour table holds 0x000, 0x555, 0xAAA and 0xFFF for codes 0 to 3. A pal_we_i cycle sets entry pal_idx_i to pal_data_i from the next clock on.
- R9: A write with wr_en_i high stores wr_data_i at wr_addr_i of bank wr_bank_i. Later scanout reads return it, and the write never shifts the raster timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Image write strobe |
| wr_bank_i | input | 4 | Bank of the image write |
| wr_addr_i | input | 11 | Word address inside the bank, {row[3:0], byte[6:0]} |
| wr_data_i | input | 8 | Four packed pixels |
| pal_we_i | input | 1 | Colour table write strobe |
| pal_idx_i | input | 2 | Colour table entry to write |
| pal_data_i | input | 12 | RGB value, 4 bits per channel |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | High on visible pixels |
| rgb_o | output | 12 | Pixel colour, zero when blanked |

## Verification
The properties assume reset is applied once at time zero and not again. Their run-length counters for the sync and enable pulses start from the idle reset state. The colour table property assumes a written entry is not overwritten in the very next cycle; the stimulus loads each entry in a single isolated strobe. The stimulus loads the image before the raster is tracked. It makes the one live write to a stored line that is displayed later in the same frame, so scanout never reads the word in the cycle it is written.

// File: rtl/vga_fb_pkg.sv
package vga_fb_pkg;
  localparam int PIX_W     = 2;
  localparam int BYTE_W    = 8;
  localparam int PPB       = BYTE_W / PIX_W;        // pixels per byte
  localparam int RGB_W     = 12;
  localparam int CNT_W     = 10;
  localparam int BANKS     = 16;
  localparam int ROW_BITS  = 4;                     // stored lines per bank = 2**ROW_BITS
  localparam int COL_BITS  = 7;                     // byte slots per line = 2**COL_BITS
  localparam int BANK_AW   = ROW_BITS + COL_BITS;
  localparam int BANK_SW   = $clog2(BANKS);
  localparam int SEL_W     = $clog2(PPB);
  localparam int COL_LSB   = 1 + SEL_W;             // one bit dropped for doubling
  localparam int PAL_N     = 1 << PIX_W;
  typedef logic [RGB_W-1:0] rgb_t;
  typedef logic [PIX_W-1:0] code_t;
endpackage

// File: rtl/vga_timing.sv
module vga_timing
  import vga_fb_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] h_o,
  output logic [CNT_W-1:0] v_o,
  output logic             act_o,
  output logic             hs_n_o,
  output logic             vs_n_o
);
  localparam logic [CNT_W-1:0] H_LAST = CNT_W'(H_VIS + H_FP + H_SYNC + H_BP - 1);
  localparam logic [CNT_W-1:0] V_LAST = CNT_W'(V_VIS + V_FP + V_SYNC + V_BP - 1);
  localparam logic [CNT_W-1:0] H_VIS_C = CNT_W'(H_VIS);
  localparam logic [CNT_W-1:0] V_VIS_C = CNT_W'(V_VIS);
  localparam logic [CNT_W-1:0] HS_BEG = CNT_W'(H_VIS + H_FP);
  localparam logic [CNT_W-1:0] HS_END = CNT_W'(H_VIS + H_FP + H_SYNC);
  localparam logic [CNT_W-1:0] VS_BEG = CNT_W'(V_VIS + V_FP);
  localparam logic [CNT_W-1:0] VS_END = CNT_W'(V_VIS + V_FP + V_SYNC);

  logic [CNT_W-1:0] h_q, v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q == H_LAST) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o    = h_q;
  assign v_o    = v_q;
  assign act_o  = (h_q < H_VIS_C) && (v_q < V_VIS_C);
  assign hs_n_o = !((h_q >= HS_BEG) && (h_q < HS_END));
  assign vs_n_o = !((v_q >= VS_BEG) && (v_q < VS_END));
endmodule

// File: rtl/fb_bank_array.sv
module fb_bank_array
  import vga_fb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BANK_AW-1:0] rd_addr_i,
  input  logic [BANK_SW-1:0] rd_bank_i,
  input  logic               wr_en_i,
  input  logic [BANK_SW-1:0] wr_bank_i,
  input  logic [BANK_AW-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  output logic [BYTE_W-1:0]  rd_data_o
);
  localparam int DEPTH = 1 << BANK_AW;

  logic [BANKS-1:0][BYTE_W-1:0] q_all;
  logic [BANK_SW-1:0]           bank_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] q;
    // every bank reads each cycle; the registered bank index picks one
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_bank_i == BANK_SW'(b))) mem[wr_addr_i] <= wr_data_i;
      q <= mem[rd_addr_i];
    end
    assign q_all[b] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= '0;
    else         bank_q <= rd_bank_i;
  end

  assign rd_data_o = q_all[bank_q];
endmodule

// File: rtl/vga_palette.sv
module vga_palette
  import vga_fb_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  code_t                       idx_i,
  input  rgb_t                        data_i,
  input  code_t                       code_i,
  output rgb_t                        rgb_o,
  output logic [PAL_N-1:0][RGB_W-1:0] pal_o
);
  logic [PAL_N-1:0][RGB_W-1:0] pal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < PAL_N; k++) pal_q[k] <= RGB_W'(k * 'h555);  // grey ramp
    end else if (we_i) begin
      pal_q[idx_i] <= data_i;
    end
  end

  assign rgb_o = pal_q[code_i];
  assign pal_o = pal_q;
endmodule

// File: rtl/vga_fb_reader.sv
module vga_fb_reader
  import vga_fb_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [BANK_SW-1:0] wr_bank_i,
  input  logic [BANK_AW-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  input  logic               pal_we_i,
  input  logic [PIX_W-1:0]   pal_idx_i,
  input  logic [RGB_W-1:0]   pal_data_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [RGB_W-1:0]   rgb_o
);
  logic [CNT_W-1:0] h, v;
  logic             act, hs_n, vs_n;

  vga_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk_i, .rst_ni, .h_o(h), .v_o(v), .act_o(act), .hs_n_o(hs_n), .vs_n_o(vs_n)
  );

  // counter bits map straight onto memory coordinates
  logic [BANK_AW-1:0] rd_addr;
  logic [BANK_SW-1:0] rd_bank;
  assign rd_addr = {v[ROW_BITS:1], h[COL_LSB+COL_BITS-1:COL_LSB]};
  assign rd_bank = v[ROW_BITS+BANK_SW:ROW_BITS+1];

  logic unused_cnt_bits;
  assign unused_cnt_bits = ^{h[0], h[CNT_W-1:COL_LSB+COL_BITS], v[0], v[CNT_W-1:ROW_BITS+BANK_SW+1]};

  logic [BYTE_W-1:0] rd_byte;

  fb_bank_array u_banks (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr), .rd_bank_i(rd_bank),
    .wr_en_i, .wr_bank_i, .wr_addr_i, .wr_data_i,
    .rd_data_o(rd_byte)
  );

  // stage 1: control delayed to match the RAM read
  logic [SEL_W-1:0] sel_q;
  logic             act_q, hs_q, vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      act_q <= 1'b0;
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
    end else begin
      sel_q <= h[COL_LSB-1:1];
      act_q <= act;
      hs_q  <= hs_n;
      vs_q  <= vs_n;
    end
  end

  code_t code;
  always_comb code = rd_byte[PIX_W*(PPB-1-int'(sel_q)) +: PIX_W];  // slot 0 in MSBs

  rgb_t                        pal_rgb;
  logic [PAL_N-1:0][RGB_W-1:0] pal_flat;

  vga_palette u_pal (
    .clk_i, .rst_ni,
    .we_i(pal_we_i), .idx_i(pal_idx_i), .data_i(pal_data_i),
    .code_i(code), .rgb_o(pal_rgb), .pal_o(pal_flat)
  );

  // stage 2: registered outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
      de_o    <= 1'b0;
      rgb_o   <= '0;
    end else begin
      hsync_o <= hs_q;
      vsync_o <= vs_q;
      de_o    <= act_q;
      rgb_o   <= act_q ? pal_rgb : '0;
    end
  end
endmodule

// File: rtl/vga_fb_reader_chk.sv
module vga_fb_reader_chk
  import vga_fb_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_SYNC = 96
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        hsync_o,
  input logic                        vsync_o,
  input logic                        de_o,
  input logic [RGB_W-1:0]            rgb_o,
  input logic                        pal_we_i,
  input logic [PIX_W-1:0]            pal_idx_i,
  input logic [RGB_W-1:0]            pal_data_i,
  input logic [PAL_N-1:0][RGB_W-1:0] pal_flat
);
  logic [CNT_W-1:0] hs_run, de_run;
  logic [PIX_W-1:0] idx_q;
  logic [RGB_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_run <= '0;
      de_run <= '0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      hs_run <= hsync_o ? '0 : hs_run + 1'b1;
      de_run <= de_o ? de_run + 1'b1 : '0;
      idx_q  <= pal_idx_i;
      data_q <= pal_data_i;
    end
  end

  p_hs_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |-> hs_run == CNT_W'(H_SYNC));

  p_hs_blank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> !de_o);

  p_vs_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_o |-> !de_o);

  p_de_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(de_o) |-> de_run == CNT_W'(H_VIS));

  p_blank_black_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> rgb_o == '0);

  p_pal_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_we_i |=> pal_flat[idx_q] == data_q);
endmodule

bind vga_fb_reader vga_fb_reader_chk #(.H_VIS(H_VIS), .H_SYNC(H_SYNC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .de_o(de_o), .rgb_o(rgb_o), .pal_we_i(pal_we_i), .pal_idx_i(pal_idx_i),
  .pal_data_i(pal_data_i), .pal_flat(pal_flat)
);

// File: tb/vga_fb_reader_tb.sv
module vga_fb_reader_tb;
  localparam int H_VIS = 64, H_FP = 4, H_SYNC = 8, H_BP = 4;
  localparam int V_VIS = 480, V_FP = 10, V_SYNC = 2, V_BP = 33;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_bank = '0;
  logic [10:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        pal_we = 1'b0;
  logic [1:0]  pal_idx = '0;
  logic [11:0] pal_data = '0;
  logic        hsync, vsync, de;
  logic [11:0] rgb;

  always #10 clk = ~clk;

  vga_fb_reader #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pal_we_i(pal_we), .pal_idx_i(pal_idx), .pal_data_i(pal_data),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .rgb_o(rgb)
  );

  int total = 0, bad = 0;
  int pal_m [4] = '{12'h000, 12'h555, 12'hAAA, 12'hFFF};

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // raster position of the current outputs, locked to the vsync falling edge
  int bx = 0, by = 0;
  bit synced = 1'b0;
  logic vs_prev = 1'b1;
  always @(posedge clk) begin
    int nx, ny;
    #1;
    if (!rst_n) begin
      synced = 1'b0;
      vs_prev = 1'b1;
    end else begin
      nx = bx + 1; ny = by;
      if (nx == H_TOT) begin
        nx = 0; ny = by + 1;
        if (ny == V_TOT) ny = 0;
      end
      if (vs_prev && !vsync) begin
        if (synced) chk("R3", "frame period", ny * H_TOT + nx, (V_VIS + V_FP) * H_TOT);
        bx = 0; by = V_VIS + V_FP; synced = 1'b1;
      end else begin
        bx = nx; by = ny;
      end
      vs_prev = vsync;
    end
  end

  task automatic wait_pos(int x, int y);
    do @(negedge clk); while (!(synced && bx == x && by == y));
  endtask

  task automatic img_wr(int bank, int addr, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 4'(bank); wr_addr = 11'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pix(string req, int x, int y, int exp);
    wait_pos(x, y);
    chk(req, $sformatf("rgb(%0d,%0d)", x, y), int'(rgb), exp);
  endtask

  task automatic test_reset();
    chk("R1", "hsync in reset", int'(hsync), 1);
    chk("R1", "vsync in reset", int'(vsync), 1);
    chk("R1", "de in reset", int'(de), 0);
    chk("R1", "rgb in reset", int'(rgb), 0);
  endtask

  task automatic load_image();
    img_wr(0, 0, 8'h1B);                 // line 0, byte 0: codes 0,1,2,3
    img_wr(0, 8, 8'hFF);                 // line 0, byte 8: blanked columns
    img_wr(0, 128 + 1, 8'hE4);           // line 1, byte 1: codes 3,2,1,0
    img_wr(14, 15 * 128 + 7, 8'h9C);     // line 239, byte 7: codes 2,1,3,0
  endtask

  task automatic test_sync();
    wait_pos(H_VIS + H_FP - 1, 491); chk("R2", "hsync before pulse", int'(hsync), 1);
    wait_pos(H_VIS + H_FP, 491);     chk("R2", "hsync pulse start", int'(hsync), 0);
    wait_pos(H_VIS + H_FP + H_SYNC - 1, 491); chk("R2", "hsync pulse last", int'(hsync), 0);
    wait_pos(H_VIS + H_FP + H_SYNC, 491);     chk("R2", "hsync after pulse", int'(hsync), 1);
    wait_pos(H_TOT - 1, 491);        chk("R3", "vsync last clock", int'(vsync), 0);
    wait_pos(0, 492);                chk("R3", "vsync released", int'(vsync), 1);
  endtask

  task automatic test_order();          // R5 R6 R7 horizontal
    int codes [4] = '{0, 1, 2, 3};
    wait_pos(0, 0); chk("R4", "de first pixel", int'(de), 1);
    for (int x = 0; x < 8; x++) pix("R6", x, 0, pal_m[codes[x / 2]]);
  endtask

  task automatic test_blank();
    wait_pos(H_VIS - 1, 0); chk("R4", "de last pixel", int'(de), 1);
    wait_pos(H_VIS, 0);     chk("R4", "de after line", int'(de), 0);
    chk("R4", "blank rgb over data", int'(rgb), 0);
    wait_pos(H_VIS + 6, 0); chk("R4", "blank rgb mid", int'(rgb), 0);
  endtask

  task automatic test_doubling();
    for (int x = 0; x < 8; x += 3) pix("R7", x, 1, pal_m[x / 2]);
    pix("R5", 8, 2, pal_m[3]);
    pix("R7", 9, 2, pal_m[3]);
    pix("R6", 10, 2, pal_m[2]);
    pix("R6", 12, 3, pal_m[1]);
    pix("R6", 15, 3, pal_m[0]);
  endtask

  task automatic test_live_write();
    wait_pos(0, 10);
    img_wr(1, 0, 8'hAA);                  // line 16 = rows 32,33
    pix("R9", 0, 32, pal_m[2]);
    pix("R9", 7, 33, pal_m[2]);
  endtask

  task automatic test_palette();
    wait_pos(0, 100);
    pal_we = 1'b1; pal_idx = 2'd2; pal_data = 12'h3C5;
    @(negedge clk);
    pal_we = 1'b0;
    pal_m[2] = 12'h3C5;
    pix("R8", 56, 478, pal_m[2]);
    pix("R5", 58, 478, pal_m[1]);
    pix("R5", 60, 479, pal_m[3]);
    pix("R5", 62, 479, pal_m[0]);
  endtask

  task automatic test_frame_end();
    wait_pos(0, V_VIS); chk("R4", "de below image", int'(de), 0);
    wait_pos(H_TOT - 1, V_VIS + V_FP - 1); chk("R3", "vsync before pulse", int'(vsync), 1);
    wait_pos(1, V_VIS + V_FP);             chk("R3", "vsync pulse", int'(vsync), 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    load_image();
    test_sync();
    test_order();
    test_blank();
    test_doubling();
    test_live_write();
    test_palette();
    test_frame_end();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule